// File: doc/BRIEF.md
# AES-128 Round-Key Step Unit

This unit advances the AES-128 key schedule by one round. It takes the current 128-bit round key as four 32-bit words, together with a 4-bit round selector. It returns the next round key after a fixed number of clock cycles. A controller expands a full cipher key by feeding each result back in with selectors 1 through 10. The unit accepts a new request on every cycle, so independent keys can stream through it back to back.

Word 0 of the key sits in bits [31:0] and word 3 in bits [127:96]. Within each word the least significant byte comes first in key order. The output uses the same packing. The last word is rotated right by eight bits. Each of its bytes then passes through the forward AES substitution. The result is combined with word 0 and a round constant to form new word 0. Each later word is the XOR of its old value with the new word just before it.

Top module: `aes128_rkey_step`

## Requirements
- R1: New word 0 (out_key[31:0]) equals old word 0 XOR the substituted value of old word 3 rotated right by 8 bits XOR the round-constant word.
- R2: After folding, selector k in 1..10 chooses the constant 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex) for k = 1..10 respectively, placed in bits [7:0] of the constant word with bits [31:8] zero; an all-zero key with selector k therefore yields word 0 = 0x63636363 XOR that constant.
- R3: A selector of 0 or of 11..15 is used with its bit 3 inverted (0 acts as 8, 11 as 3, 15 as 7); selectors 1..10 are used unchanged.
- R4: New words 1, 2 and 3 are each the XOR of the old word at the same position and the new word one position lower.
- R5: Word i occupies bits [32*i+31:32*i] on both in_key and out_key, so flipping bits of old word 0 flips exactly the same bits of every new word.
- R6: out_valid rises exactly PIPE_STAGES clock cycles after a cycle with in_valid high, and requests on consecutive cycles give results on consecutive cycles in order.
- R7: While out_valid is low, out_key keeps the last result.
- R8: While rst_n is low, and after reset until the first result, out_valid is 0 and out_key is all zeros.
- R9: The byte substitution is the AES forward S-box, so chaining selectors 1..10 from the standard example key 2b7e151628aed2a6abf7158809cf4f3c gives the published first and tenth round keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A request is presented this cycle |
| in_key | input | 128 | Current round key, word 0 in bits [31:0] |
| in_round | input | 4 | Round selector, folded into 1..10 |
| out_valid | output | 1 | out_key holds a new result this cycle |
| out_key | output | 128 | Next round key, same packing as in_key |

## Verification
Every result appears PIPE_STAGES rising edges after the edge that accepted its request. There are two with the default setting: one edge loads the substituted word, and the next loads the chained words. Single-request tasks drive on a falling edge. They wait exactly that many falling edges before they sample out_valid and out_key. The streaming task keeps a bench-side delay line of the same depth, so each falling-edge sample is compared with the request issued PIPE_STAGES cycles earlier. Idle cycles in that line also check that out_valid stays low and that out_key holds its value.

// File: rtl/aes_rk_pkg.sv
package aes_rk_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int KEY_W   = WORD_W * NWORDS;
  localparam int SEL_W   = 4;
  localparam int NROUNDS = 10;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] b;
    logic [7:0] e;
    r = 8'h01;
    b = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, b);
      b = gf_mul(b, b);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_sbox(input logic [7:0] x);
    logic [7:0] q;
    q = gf_inv(x);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction

  // bring selector into 1..NROUNDS by flipping bit 3
  function automatic logic [SEL_W-1:0] fold_sel(input logic [SEL_W-1:0] s);
    if (s == '0 || s > SEL_W'(NROUNDS)) return s ^ SEL_W'(8);
    return s;
  endfunction

  function automatic logic [7:0] rcon_byte(input logic [SEL_W-1:0] k);
    logic [7:0] c;
    case (k)
      4'd1:    c = 8'h01;
      4'd2:    c = 8'h02;
      4'd3:    c = 8'h04;
      4'd4:    c = 8'h08;
      4'd5:    c = 8'h10;
      4'd6:    c = 8'h20;
      4'd7:    c = 8'h40;
      4'd8:    c = 8'h80;
      4'd9:    c = 8'h1b;
      4'd10:   c = 8'h36;
      default: c = 8'h00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/aes_rk_sbox.sv
module aes_rk_sbox (
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out
);
  import aes_rk_pkg::*;
  always_comb byte_out = fwd_sbox(byte_in);
endmodule

// File: rtl/aes_rk_subword.sv
module aes_rk_subword #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] word_in,
  output logic [8*LANES-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aes_rk_sbox u_sbox (
      .byte_in  (word_in[8*g +: 8]),
      .byte_out (word_out[8*g +: 8])
    );
  end
endmodule

// File: rtl/aes_rk_round_ctl.sv
module aes_rk_round_ctl
  import aes_rk_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_in,
  output logic [WORD_W-1:0] rcon_word
);
  logic [SEL_W-1:0] sel_eff;
  always_comb begin
    sel_eff   = fold_sel(sel_in);
    rcon_word = {{(WORD_W-8){1'b0}}, rcon_byte(sel_eff)};
  end
endmodule

// File: rtl/aes128_rkey_step.sv
module aes128_rkey_step
  import aes_rk_pkg::*;
#(
  parameter int PIPE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic [SEL_W-1:0] in_round,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key
);
  localparam int ROT = 8;

  // stage A: rotate, substitute, add constant
  logic [WORD_W-1:0] last_w, rot_w, sub_w, rcon_w, mix_a;
  always_comb begin
    last_w = in_key[KEY_W-1 -: WORD_W];
    rot_w  = {last_w[ROT-1:0], last_w[WORD_W-1:ROT]};
    mix_a  = sub_w ^ rcon_w;
  end

  aes_rk_subword #(.LANES(WORD_W/8)) u_subword (
    .word_in  (rot_w),
    .word_out (sub_w)
  );

  aes_rk_round_ctl u_ctl (
    .sel_in    (in_round),
    .rcon_word (rcon_w)
  );

  // optional middle register
  logic             mid_valid;
  logic [KEY_W-1:0] mid_key;
  logic [WORD_W-1:0] mid_mix;

  if (PIPE_STAGES == 2) begin : g_mid_reg
    logic              mid_valid_q, mid_valid_d;
    logic [KEY_W-1:0]  mid_key_q, mid_key_d;
    logic [WORD_W-1:0] mid_mix_q, mid_mix_d;
    always_comb begin
      mid_valid_d = in_valid;
      mid_key_d   = mid_key_q;
      mid_mix_d   = mid_mix_q;
      if (in_valid) begin
        mid_key_d = in_key;
        mid_mix_d = mix_a;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_valid_q <= 1'b0;
        mid_key_q   <= '0;
        mid_mix_q   <= '0;
      end else begin
        mid_valid_q <= mid_valid_d;
        mid_key_q   <= mid_key_d;
        mid_mix_q   <= mid_mix_d;
      end
    end
    assign mid_valid = mid_valid_q;
    assign mid_key   = mid_key_q;
    assign mid_mix   = mid_mix_q;
  end else begin : g_mid_wire
    assign mid_valid = in_valid;
    assign mid_key   = in_key;
    assign mid_mix   = mix_a;
  end

  // stage B: chain the words
  logic [KEY_W-1:0] chain_key;
  always_comb begin
    chain_key[WORD_W-1:0] = mid_key[WORD_W-1:0] ^ mid_mix;
    for (int i = 1; i < NWORDS; i++)
      chain_key[WORD_W*i +: WORD_W] = mid_key[WORD_W*i +: WORD_W] ^ chain_key[WORD_W*(i-1) +: WORD_W];
  end

  logic             out_valid_d;
  logic [KEY_W-1:0] out_key_d;
  always_comb begin
    out_valid_d = mid_valid;
    out_key_d   = out_key;
    if (mid_valid) out_key_d = chain_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_key   <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_key   <= out_key_d;
    end
  end
endmodule

// File: rtl/aes128_rkey_step_chk.sv
module aes128_rkey_step_chk
  import aes_rk_pkg::*;
#(
  parameter int PIPE_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [KEY_W-1:0] in_key,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_key
);
  logic [1:0]       v_hist;
  logic [KEY_W-1:0] k_hist [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_hist    <= '0;
      k_hist[0] <= '0;
      k_hist[1] <= '0;
    end else begin
      v_hist    <= {v_hist[0], in_valid};
      k_hist[0] <= in_key;
      k_hist[1] <= k_hist[0];
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_hist[PIPE_STAGES-1]); // R6
  AST_CHAIN_W1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_key[63:32] ^ out_key[31:0]) == k_hist[PIPE_STAGES-1][63:32])); // R4
  AST_CHAIN_W2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_key[95:64] ^ out_key[63:32]) == k_hist[PIPE_STAGES-1][95:64])); // R4
  AST_CHAIN_W3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_key[127:96] ^ out_key[95:64]) == k_hist[PIPE_STAGES-1][127:96])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_key)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_key == '0)); // R8
endmodule

bind aes128_rkey_step aes128_rkey_step_chk #(.PIPE_STAGES(PIPE_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_key    (in_key),
  .out_valid (out_valid),
  .out_key   (out_key)
);

// File: tb/aes128_rkey_step_test.sv
module aes128_rkey_step_test;
  localparam int LAT = 2;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_key;
  logic [3:0]   in_round;
  logic         out_valid;
  logic [127:0] out_key;

  int n_checks = 0;
  int n_fail   = 0;

  aes128_rkey_step #(.PIPE_STAGES(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .in_round(in_round), .out_valid(out_valid), .out_key(out_key)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- bench model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    s = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s;
  endfunction

  function automatic logic [7:0] m_rcon(input int k);
    logic [7:0] c = 8'h01;
    for (int i = 1; i < k; i++) c = m_mul(c, 8'h02);
    return c;
  endfunction

  function automatic int m_fold(input int s);
    return (s == 0 || s > 10) ? (s ^ 8) : s;
  endfunction

  function automatic logic [127:0] m_next(input logic [127:0] k, input int sel);
    logic [31:0] w [4];
    logic [31:0] t;
    logic [31:0] n [4];
    for (int i = 0; i < 4; i++) w[i] = k[32*i +: 32];
    t = (w[3] >> 8) | (w[3] << 24);
    for (int b = 0; b < 4; b++) t[8*b +: 8] = m_sbox(t[8*b +: 8]);
    n[0] = w[0] ^ t ^ {24'h0, m_rcon(m_fold(sel))};
    for (int i = 1; i < 4; i++) n[i] = w[i] ^ n[i-1];
    return {n[3], n[2], n[1], n[0]};
  endfunction

  // standard big-endian word into the packed byte order
  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [127:0] pack_std(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] c, input logic [31:0] d);
    return {bsw(d), bsw(c), bsw(b), bsw(a)};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [127:0] k, input logic [3:0] sel, output logic [127:0] res, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_key = k; in_round = sel;
    @(negedge clk);
    in_valid = 1'b0; in_key = '0; in_round = '0;
    repeat (LAT-1) @(negedge clk);
    check(out_valid === 1'b1, req, {127'h0, out_valid}, 128'h1);
    res = out_key;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_round = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_key === '0, "R8 in reset", out_key, 128'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_key === '0, "R8 after release", out_key, 128'h0);
  endtask

  task automatic t_std_chain();
    logic [127:0] k, r, e1, e10;
    k   = pack_std(32'h2b7e1516, 32'h28aed2a6, 32'habf71588, 32'h09cf4f3c);
    e1  = pack_std(32'ha0fafe17, 32'h88542cb1, 32'h23a33939, 32'h2a6c7605);
    e10 = pack_std(32'hd014f9a8, 32'hc9ee2589, 32'he13f0cc8, 32'hb6630ca6);
    for (int s = 1; s <= 10; s++) begin
      run_one(k, 4'(s), r, "R9 chain");
      check(r === m_next(k, s), "R1 chain step", r, m_next(k, s));
      if (s == 1)  check(r === e1, "R9 first round key", r, e1);
      if (s == 10) check(r === e10, "R9 tenth round key", r, e10);
      k = r;
    end
  endtask

  task automatic t_rcon();
    logic [127:0] r;
    logic [127:0] e;
    for (int s = 1; s <= 10; s++) begin
      run_one('0, 4'(s), r, "R2");
      e = m_next('0, s);
      check(r[31:0] === (32'h63636363 ^ {24'h0, m_rcon(s)}), "R2 constant word", {96'h0, r[31:0]}, {96'h0, e[31:0]});
    end
  endtask

  task automatic t_fold();
    logic [127:0] k, r0, r8, r11, r3, r15, r7, r12;
    k = {32'h0f1e2d3c, 32'h4b5a6978, 32'h8796a5b4, 32'hc3d2e1f0};
    run_one(k, 4'd0,  r0,  "R3"); run_one(k, 4'd8, r8, "R3");
    run_one(k, 4'd11, r11, "R3"); run_one(k, 4'd3, r3, "R3");
    run_one(k, 4'd15, r15, "R3"); run_one(k, 4'd7, r7, "R3");
    run_one(k, 4'd12, r12, "R3");
    check(r0 === r8,  "R3 sel 0 acts as 8", r0, r8);
    check(r11 === r3, "R3 sel 11 acts as 3", r11, r3);
    check(r15 === r7, "R3 sel 15 acts as 7", r15, r7);
    check(r12 === m_next(k, 4), "R3 sel 12 acts as 4", r12, m_next(k, 4));
  endtask

  task automatic t_packing();
    logic [127:0] base, flip, rb, rf;
    base = {32'h11223344, 32'h55667788, 32'h99aabbcc, 32'hddeeff00};
    flip = base ^ 128'h0000_0000_0000_0000_0000_0000_a5a5_0001;
    run_one(base, 4'd5, rb, "R5");
    run_one(flip, 4'd5, rf, "R5");
    check((rb ^ rf) === {4{32'ha5a50001}}, "R5 word 0 position", rb ^ rf, {4{32'ha5a50001}});
    check(rb[127:32] === (base[127:32] ^ rb[95:0]), "R4 chained words", rb[127:32], base[127:32] ^ rb[95:0]);
  endtask

  task automatic t_stream();
    logic         qv [LAT];
    logic [127:0] qk [LAT];
    logic [127:0] held;
    logic [127:0] k;
    int cyc_sel;
    for (int i = 0; i < LAT; i++) begin qv[i] = 1'b0; qk[i] = '0; end
    k = 128'h3243f6a8_885a308d_313198a2_e0370734;
    held = out_key;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (qv[LAT-1]) begin
        check(out_valid === 1'b1, "R6 stream valid", {127'h0, out_valid}, 128'h1);
        check(out_key === qk[LAT-1], "R6 stream data", out_key, qk[LAT-1]);
        held = out_key;
      end else begin
        check(out_valid === 1'b0, "R6 stream bubble", {127'h0, out_valid}, 128'h0);
        check(out_key === held, "R7 hold while idle", out_key, held);
      end
      for (int i = LAT-1; i > 0; i--) begin qv[i] = qv[i-1]; qk[i] = qk[i-1]; end
      cyc_sel = c % 16;
      in_valid = (c < 34) && ((c % 7) != 3) && ((c % 7) != 4);
      k = {k[95:0], k[127:96] ^ 32'(c * 32'h9e3779b9)};
      in_key = k;
      in_round = 4'(cyc_sel);
      qv[0] = in_valid;
      qk[0] = m_next(k, cyc_sel);
    end
    in_valid = 1'b0;
  endtask

  // ---------------- sequencer ----------------
  initial begin
    t_reset();
    t_std_chain();
    t_rcon();
    t_fold();
    t_packing();
    t_stream();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule